// File: doc/BRIEF.md
# Configurable Processor Register Bus Port

This block sits between an external processor and a small internal register file and turns processor bus cycles into single-cycle internal read and write strobes with an address and write data. Three configuration pins are captured while reset is held and then stay fixed until the next reset. They choose the bus topology (generic or split), the strobe convention (separate read/write strobes or a direction line plus a data strobe), and, in split mode, how the register address is captured (an address-latch pulse or an A0 index line).

In generic mode the processor presents an 8-bit address and a 16-bit data word on separate buses. In split mode the 16-bit data bus is left to DMA traffic. Registers are then reached over an 8-bit multiplexed address/data bus: a register index is loaded first, and each 16-bit register is moved as two byte accesses, low byte first. All bus inputs are treated as synchronous to `clk`. Output drive is modelled by output-enable signals rather than tri-state nets.

Top module: `cpu_bus_port`

## Requirements
- R1: `cfg_generic` (1 = generic, 0 = split), `cfg_sep_strb` and `cfg_a0_mode` are captured on every clock edge while `rst_n` is low. Changes after reset has been released have no effect on behaviour.
- R2: In generic mode, a write cycle stores `data_in` into the register selected by `addr_in`. A read cycle drives that register's contents on `data_out` with `data_oe` high. All registers read 0 after reset.
- R3: With `cfg_sep_strb`=1, `rd_ds_n` is an active-low read strobe and `wr_rw` is an active-low write strobe. With `cfg_sep_strb`=0, `rd_ds_n` is an active-low data strobe and `wr_rw` gives the direction (1 = read, 0 = write).
- R4: While `cs_n` is high, strobes cause no register write, no index load and no output enable.
- R5: `data_oe` and `ad_oe` are high only while `cs_n` is low and a read is active. In split mode, register reads appear only on `ad_out`, and `data_oe` stays low.
- R6: In split mode with `cfg_a0_mode`=0, each clock with `ale_a0` high and `cs_n` low loads `ad_in` into the register index and selects the low byte.
- R7: In split mode with `cfg_a0_mode`=1, a write with `ale_a0`=0 loads the index from `ad_in`. Accesses with `ale_a0`=1 move register data. A read with `ale_a0`=0 returns the current index on `ad_out`.
- R8: In split mode, the first data access to a register moves bits [7:0] and the second moves bits [15:8]. The register is written when the high byte is written. The index increments by one after each high-byte read or write.
- R9: Only registers 0 to 3 exist. Reads at any other address return 0, and writes to any other address change nothing.
- R10: Every write cycle produces `reg_wr` for exactly one clock, in the first clock of the strobe, with `reg_addr` and `reg_wdata` valid. In split mode this pulse occurs on the high-byte write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration pins are captured while low |
| cfg_generic | input | 1 | 1 = generic topology, 0 = split topology |
| cfg_sep_strb | input | 1 | 1 = separate read/write strobes, 0 = direction plus data strobe |
| cfg_a0_mode | input | 1 | Split mode: 1 = A0 indexing, 0 = address-latch pulse |
| cs_n | input | 1 | Active-low chip select |
| rd_ds_n | input | 1 | Read strobe or data strobe, active low |
| wr_rw | input | 1 | Write strobe (active low) or read/write direction |
| ale_a0 | input | 1 | Address-latch pulse or A0 line, depending on mode |
| addr_in | input | 8 | Generic-mode register address |
| data_in | input | 16 | Generic-mode write data |
| data_out | output | 16 | Generic-mode read data |
| data_oe | output | 1 | Drive enable for `data_out` |
| ad_in | input | 8 | Split-mode multiplexed bus, inbound |
| ad_out | output | 8 | Split-mode multiplexed bus, outbound |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| reg_wr | output | 1 | Internal register write strobe |
| reg_rd | output | 1 | Internal register read strobe |
| reg_addr | output | 8 | Internal register address |
| reg_wdata | output | 16 | Internal register write data |

## Verification
The bench sweeps all six legal pin configurations. In each one it inverts the configuration pins right after reset, so any dependence on live pins shows up at once. Every configuration writes a distinct arithmetic pattern to addresses 0 to 5 and reads them back. This separates correct decoding from aliasing, and separates the four real registers from the empty addresses. The split configurations also check the byte order and the index stepping that follows each high byte. Extra patterns issue strobes with chip select high, and in A0 mode read back the index itself. These show that deselected cycles change nothing and that index cycles are kept apart from data cycles.

// File: rtl/cpu_bus_port.sv
module cpu_bus_port #(
  parameter int NREG = 4,
  parameter int AW   = 8,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_generic,
  input  logic          cfg_sep_strb,
  input  logic          cfg_a0_mode,
  input  logic          cs_n,
  input  logic          rd_ds_n,
  input  logic          wr_rw,
  input  logic          ale_a0,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic [7:0]    ad_in,
  output logic [7:0]    ad_out,
  output logic          ad_oe,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic gen_q, sep_q, a0m_q;
  logic rd_q, wr_q, rd_dat_q, hi;
  logic [AW-1:0] idx;
  logic [7:0] lo_buf;
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk)
    if (!rst_n) begin
      gen_q <= cfg_generic;
      sep_q <= cfg_sep_strb;
      a0m_q <= cfg_a0_mode;
    end

  wire sel    = !cs_n;
  wire rd_act = sel && (sep_q ? !rd_ds_n : (!rd_ds_n && wr_rw));
  wire wr_act = sel && (sep_q ? !wr_rw   : (!rd_ds_n && !wr_rw));
  wire wr_go  = wr_act && !wr_q;
  wire rd_go  = rd_act && !rd_q;
  wire rd_end = !rd_act && rd_q;
  wire dat_ph = gen_q || !a0m_q || ale_a0;
  wire idx_ld = !gen_q && sel && (a0m_q ? (wr_go && !ale_a0) : ale_a0);
  wire sw     = !gen_q && wr_go && dat_ph && !idx_ld;

  wire [AW-1:0] acc_addr = gen_q ? addr_in : idx;
  wire          in_rng   = acc_addr < AW'(NREG);
  wire [DW-1:0] rdat     = in_rng ? regs[acc_addr[IW-1:0]] : '0;

  assign reg_addr  = acc_addr;
  assign reg_wdata = gen_q ? data_in : {ad_in, lo_buf};
  assign reg_wr    = gen_q ? wr_go : (sw && hi);
  assign reg_rd    = rd_go && dat_ph && (gen_q || !hi);
  assign data_oe   = gen_q && rd_act;
  assign data_out  = rdat;
  assign ad_oe     = !gen_q && rd_act;
  assign ad_out    = !dat_ph ? idx[7:0] : (hi ? rdat[15:8] : rdat[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0; wr_q <= 1'b0; rd_dat_q <= 1'b0; hi <= 1'b0;
      idx <= '0; lo_buf <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      rd_q     <= rd_act;
      wr_q     <= wr_act;
      rd_dat_q <= rd_act && dat_ph;
      if (reg_wr && in_rng) regs[acc_addr[IW-1:0]] <= reg_wdata;
      if (idx_ld) begin
        idx <= AW'(ad_in);
        hi  <= 1'b0;
      end else if (sw) begin
        if (hi) begin
          hi  <= 1'b0;
          idx <= idx + 1'b1;
        end else begin
          lo_buf <= ad_in;
          hi     <= 1'b1;
        end
      end else if (!gen_q && rd_end && rd_dat_q) begin
        hi <= !hi;
        if (hi) idx <= idx + 1'b1;
      end
    end
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable({gen_q, sep_q, a0m_q})); // R1
  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe || ad_oe) |-> !cs_n); // R5
  AST_SPLIT_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |-> !data_oe); // R5
  AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !cs_n); // R4
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R10
  AST_HI_STEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_q && reg_wr) |=> (idx == AW'($past(idx) + 1'b1)) && !hi); // R8
endmodule

// File: tb/test_cpu_bus_port.sv
module test_cpu_bus_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_generic = 1'b1, cfg_sep_strb = 1'b1, cfg_a0_mode = 1'b0;
  logic cs_n = 1'b1, rd_ds_n = 1'b1, wr_rw = 1'b1, ale_a0 = 1'b0;
  logic [7:0] addr_in = '0, ad_in = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out, reg_wdata;
  logic [7:0] ad_out, reg_addr;
  logic data_oe, ad_oe, reg_wr, reg_rd;

  cpu_bus_port i_cpu_bus_port (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit gen, sep, a0m;
  logic w1, w2, r_doe, r_aoe, r_rd, r_post;
  logic [7:0] w_addr, r_ad;
  logic [15:0] w_data, r_data;

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] val(int c, int i);
    return 16'((i + 1) * 16'h0123) ^ 16'(c * 16'h1100) ^ 16'h8001;
  endfunction

  task automatic strb(bit rd, bit on);
    if (sep) begin rd_ds_n = !(on && rd); wr_rw = !(on && !rd); end
    else begin rd_ds_n = !on; wr_rw = on ? rd : 1'b1; end
  endtask

  task automatic wr_cyc(logic [7:0] a, logic [15:0] d, bit a0v, logic [7:0] adv, bit cs);
    @(negedge clk);
    addr_in = a; data_in = d; ale_a0 = a0v; ad_in = adv; cs_n = !cs; strb(0, 1);
    #1 w1 = reg_wr; w_addr = reg_addr; w_data = reg_wdata;
    @(negedge clk);
    #1 w2 = reg_wr;
    strb(0, 0); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_cyc(logic [7:0] a, bit a0v, bit cs);
    @(negedge clk);
    addr_in = a; ale_a0 = a0v; cs_n = !cs; strb(1, 1);
    #1 r_doe = data_oe; r_aoe = ad_oe; r_data = data_out; r_ad = ad_out; r_rd = reg_rd;
    @(negedge clk);
    strb(1, 0); cs_n = 1'b1;
    #1 r_post = data_oe | ad_oe;
    @(negedge clk);
  endtask

  task automatic ale_pulse(logic [7:0] ix, bit cs);
    @(negedge clk);
    ale_a0 = 1'b1; ad_in = ix; cs_n = !cs;
    @(negedge clk);
    ale_a0 = 1'b0; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_index(logic [7:0] ix);
    if (a0m) wr_cyc(0, 0, 1'b0, ix, 1'b1);
    else ale_pulse(ix, 1'b1);
  endtask

  initial begin
    for (int c = 0; c < 6; c++) begin
      gen = (c < 2);
      sep = gen ? (c == 0) : c[0];
      a0m = gen ? 1'b0 : c[1];
      rst_n = 1'b0; cs_n = 1'b1; rd_ds_n = 1'b1; wr_rw = 1'b1; ale_a0 = 1'b0;
      cfg_generic = gen; cfg_sep_strb = sep; cfg_a0_mode = a0m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cfg_generic = !gen; cfg_sep_strb = !sep; cfg_a0_mode = !a0m;
      #1;
      if (c == 0) begin
        check("R2 reset data_oe", data_oe, 0);
        check("R5 reset ad_oe", ad_oe, 0);
        check("R10 reset reg_wr", reg_wr, 0);
        rd_cyc(0, 1'b0, 1'b1);
        check("R2 reset register value", r_data, 0);
      end
      if (gen) begin
        for (int i = 0; i < 6; i++) begin
          wr_cyc(8'(i), val(c, i), 1'b0, 8'h00, 1'b1);
          check("R3 R1 write strobe decoded", w1, 1);
          check("R10 write pulse one cycle", w2, 0);
          check("R2 reg_addr", w_addr, i);
          check("R2 reg_wdata", w_data, val(c, i));
        end
        for (int i = 0; i < 6; i++) begin
          rd_cyc(8'(i), 1'b0, 1'b1);
          check("R2 data_oe on read", r_doe, 1);
          check("R9 R2 read value", r_data, (i < 4) ? val(c, i) : 16'h0);
          check("R5 ad_oe idle in generic", r_aoe, 0);
          check("R5 oe drops after strobe", r_post, 0);
        end
        wr_cyc(8'd1, 16'hDEAD, 1'b0, 8'h00, 1'b0);
        check("R4 no write without cs", w1, 0);
        rd_cyc(8'd1, 1'b0, 1'b0);
        check("R4 no oe without cs", r_doe, 0);
        rd_cyc(8'd1, 1'b0, 1'b1);
        check("R4 register unchanged", r_data, val(c, 1));
      end else begin
        set_index(8'd0);
        for (int i = 0; i < 6; i++) begin
          wr_cyc(0, 0, a0m, val(c, i)[7:0], 1'b1);
          check("R8 no write on low byte", w1, 0);
          wr_cyc(0, 0, a0m, val(c, i)[15:8], 1'b1);
          check("R8 write on high byte", w1, 1);
          check("R10 split pulse one cycle", w2, 0);
          check("R8 index auto-increment", w_addr, i);
          check("R8 assembled word", w_data, val(c, i));
        end
        set_index(8'd0);
        for (int i = 0; i < 6; i++) begin
          logic [15:0] e;
          e = (i < 4) ? val(c, i) : 16'h0;
          rd_cyc(0, a0m, 1'b1);
          check("R8 low byte first", r_ad, e[7:0]);
          check("R5 ad_oe on split read", r_aoe, 1);
          check("R1 R5 data bus quiet in split", r_doe, 0);
          check("R10 reg_rd on low byte", r_rd, 1);
          rd_cyc(0, a0m, 1'b1);
          check("R9 R8 high byte", r_ad, e[15:8]);
          check("R5 oe drops after strobe", r_post, 0);
        end
        if (a0m) begin
          set_index(8'd2);
          rd_cyc(0, 1'b0, 1'b1);
          check("R7 index readback", r_ad, 8'd2);
          rd_cyc(0, 1'b1, 1'b1);
          check("R7 data at loaded index", r_ad, val(c, 2)[7:0]);
          wr_cyc(0, 0, 1'b0, 8'd0, 1'b0);
          rd_cyc(0, 1'b0, 1'b1);
          check("R4 index kept without cs", r_ad, 8'd2);
        end else begin
          set_index(8'd3);
          ale_pulse(8'd0, 1'b0);
          rd_cyc(0, 1'b0, 1'b1);
          check("R6 R4 ALE ignored without cs", r_ad, val(c, 3)[7:0]);
          ale_pulse(8'd1, 1'b1);
          rd_cyc(0, 1'b0, 1'b1);
          check("R6 ALE loads index", r_ad, val(c, 1)[7:0]);
        end
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule